// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the control and status word that sits beside a floating-point datapath. It stores a two-bit rounding selector, a denormal-flush control, five trap enables, five sticky flags and five per-operation cause bits. When the datapath finishes an operation, it reports five raw exception indications. The block replaces the cause field with them and ORs them into the sticky flags. If any new cause is also enabled, the block raises a one-cycle trap request that carries a fixed exception code.

Software writes the whole word through a fixed mask of implemented bits. A write takes priority over an operation that completes in the same cycle. The block also decodes the rounding selector and the flush bit into two plain control lines for the datapath. An approximate reciprocal-square-root operation is flagged separately. For that operation inexact is forced only when no other indication is present.

The trap sequencer has two states. QUIET has no trap pending. TRAP drives the trap request for one cycle. The transitions are:
- QUIET to TRAP when an applied completion has an enabled cause.
- TRAP to TRAP when another enabled completion follows back to back.
- TRAP to QUIET, or QUIET to QUIET, in every other cycle.

Top module: `fpsr_unit`

## Requirements
- R1: After reset the status word reads 0, trap_req is 0 and trap_code is 0.
- R2: The status word layout is as follows. Bits 1:0 are the rounding selector. Bits 6:2 are the flags, bits 11:7 the enables and bits 16:12 the causes. Bit 18 is the denormal-flush control. Inside each five-bit field, bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. A software write stores wr_data AND 0x0005_FFFF, so every other bit reads 0.
- R3: A completion without a write replaces the cause field with op_exc, using the same bit order. The cause field becomes zero when no indication is present.
- R4: On a completion, the new causes are ORed into the flags. Flags never clear except through a write. Enables, the rounding selector and the flush bit keep their values.
- R5: When op_approx is set and op_exc is zero, the cause becomes inexact only (5'b00001). When op_approx is set and op_exc is non-zero, op_exc is used unchanged.
- R6: trap_req is high in the cycle after a completion exactly when (new cause AND enables) is non-zero, and it stays high for one cycle per such completion. While it is high, trap_code is 0x120. Otherwise trap_code is 0.
- R7: round_trunc is 1 exactly when the rounding selector equals 1. Every other value selects round-to-nearest-even, shown as round_trunc 0.
- R8: flush_denorm equals bit 18 of the status word.
- R9: When wr_en and op_done are high in the same cycle, only the write is applied. That completion changes no cause or flag and raises no trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| op_done | input | 1 | Datapath operation completed this cycle |
| op_exc | input | 5 | Raw indications: bit4 invalid, bit3 divide-by-zero, bit2 overflow, bit1 underflow, bit0 inexact |
| op_approx | input | 1 | Completed operation is the reciprocal-square-root approximation |
| csr_q | output | 32 | Current status word |
| round_trunc | output | 1 | Datapath rounds toward zero |
| flush_denorm | output | 1 | Datapath flushes denormals to zero |
| trap_req | output | 1 | Floating-point trap request |
| trap_code | output | 12 | Exception code while trap_req is high, else 0 |

## Verification
A software write and an operation completion can land in the same cycle. In that case the write must win: the completion is dropped entirely, so no cause or flag bits change and no trap is raised. The bench provokes this collision in two forms. In one, the completion carries an enabled overflow and the write clears all flags. In the other, the completion carries invalid and the write sets new enables. The bench judges the result by comparing the full status word with the masked write value and by checking that trap_req stays low in the following cycle.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned EXC_W    = 5;
    localparam int unsigned RM_LSB   = 0;
    localparam int unsigned RM_W     = 2;
    localparam int unsigned FLAG_LSB = 2;
    localparam int unsigned EN_LSB   = FLAG_LSB + EXC_W;
    localparam int unsigned CAUSE_LSB = EN_LSB + EXC_W;
    localparam int unsigned FLUSH_BIT = 18;
    localparam logic [RM_W-1:0] RM_TRUNC = 2'd1;
    localparam logic [DATA_W-1:0] IMPL_MASK =
        DATA_W'((64'd1 << (CAUSE_LSB + EXC_W)) - 64'd1) | (DATA_W'(1) << FLUSH_BIT);
    localparam int unsigned INEXACT_POS = 0;

    typedef logic [EXC_W-1:0] exc_t;

    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_TRAP  = 1'b1
    } trap_state_t;
endpackage

// File: rtl/fpsr_cause_gen.sv
module fpsr_cause_gen
    import fpsr_pkg::*;
(
    input  exc_t raw_exc,
    input  logic approx,
    output exc_t cause
);
    exc_t forced;

    always_comb begin
        forced = '0;
        forced[INEXACT_POS] = 1'b1;
        if (approx && (raw_exc == '0)) begin
            cause = forced;
        end else begin
            cause = raw_exc;
        end
    end

    always_comb begin
        if (approx && raw_exc == '0) begin
            a_r5_forced_inexact_only: assert ($onehot0(cause) && cause[INEXACT_POS]);
        end
    end
endmodule

// File: rtl/fpsr_ctrl_decode.sv
module fpsr_ctrl_decode
    import fpsr_pkg::*;
(
    input  logic [RM_W-1:0] rm,
    input  logic            dn,
    output logic            round_trunc,
    output logic            flush_denorm
);
    always_comb begin
        round_trunc  = (rm == RM_TRUNC);
        flush_denorm = dn;
    end
endmodule

// File: rtl/fpsr_trap_fsm.sv
module fpsr_trap_fsm #(
    parameter int unsigned CODE_W    = 12,
    parameter logic [CODE_W-1:0] TRAP_CODE = 12'h120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);
    import fpsr_pkg::*;

    trap_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: state_d = fire ? ST_TRAP : ST_QUIET;
            ST_TRAP:  state_d = fire ? ST_TRAP : ST_QUIET;
            default:  state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        trap_req  = 1'b0;
        trap_code = '0;
        unique case (state_q)
            ST_QUIET: ;
            ST_TRAP: begin
                trap_req  = 1'b1;
                trap_code = TRAP_CODE;
            end
            default: ;
        endcase
    end

    a_r6_trap_follows_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> trap_req);
    a_r6_no_trap_without_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !trap_req);
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit #(
    parameter int unsigned CODE_W = 12,
    parameter logic [CODE_W-1:0] TRAP_CODE = 12'h120
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [fpsr_pkg::DATA_W-1:0] wr_data,
    input  logic                        op_done,
    input  logic [fpsr_pkg::EXC_W-1:0]  op_exc,
    input  logic                        op_approx,
    output logic [fpsr_pkg::DATA_W-1:0] csr_q,
    output logic                        round_trunc,
    output logic                        flush_denorm,
    output logic                        trap_req,
    output logic [CODE_W-1:0]           trap_code
);
    import fpsr_pkg::*;

    logic [DATA_W-1:0] csr_r;
    exc_t cause_new;
    exc_t flags_cur, en_cur, cause_cur;
    logic apply_op;
    logic fire;

    assign flags_cur = csr_r[FLAG_LSB +: EXC_W];
    assign en_cur    = csr_r[EN_LSB +: EXC_W];
    assign cause_cur = csr_r[CAUSE_LSB +: EXC_W];
    assign apply_op  = op_done && !wr_en;
    assign fire      = apply_op && ((cause_new & en_cur) != '0);
    assign csr_q     = csr_r;

    fpsr_cause_gen u_cause (
        .raw_exc (op_exc),
        .approx  (op_approx),
        .cause   (cause_new)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_r <= '0;
        end else if (wr_en) begin
            csr_r <= wr_data & IMPL_MASK;
        end else if (op_done) begin
            csr_r[CAUSE_LSB +: EXC_W] <= cause_new;
            csr_r[FLAG_LSB +: EXC_W]  <= flags_cur | cause_new;
        end
    end

    fpsr_ctrl_decode u_decode (
        .rm           (csr_r[RM_LSB +: RM_W]),
        .dn           (csr_r[FLUSH_BIT]),
        .round_trunc  (round_trunc),
        .flush_denorm (flush_denorm)
    );

    fpsr_trap_fsm #(
        .CODE_W    (CODE_W),
        .TRAP_CODE (TRAP_CODE)
    ) u_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .trap_req  (trap_req),
        .trap_code (trap_code)
    );

    a_r3_cause_replaced: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !wr_en && !op_approx) |=> (cause_cur == $past(op_exc)));
    a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((flags_cur & $past(flags_cur)) == $past(flags_cur)) && $stable(en_cur));
    a_r6_trap_has_enabled_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_code == TRAP_CODE) && ((cause_cur & en_cur) != '0));
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (csr_r == ($past(wr_data) & IMPL_MASK)) && !trap_req);
endmodule

// File: tb/fpsr_unit_bench.sv
module fpsr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        op_approx = 1'b0;
    logic [31:0] csr_q;
    logic        round_trunc, flush_denorm, trap_req;
    logic [11:0] trap_code;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fpsr_unit u_fpsr_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_done(op_done), .op_exc(op_exc), .op_approx(op_approx),
        .csr_q(csr_q), .round_trunc(round_trunc), .flush_denorm(flush_denorm),
        .trap_req(trap_req), .trap_code(trap_code)
    );

    // {exc[16:12], approx[11], cause[10:6], flags[5:1], trap[0]}; enables = overflow only
    localparam int NVEC = 6;
    localparam logic [16:0] VEC [NVEC] = '{
        {5'b00001, 1'b0, 5'b00001, 5'b00001, 1'b0},
        {5'b00100, 1'b0, 5'b00100, 5'b00101, 1'b1},
        {5'b00000, 1'b0, 5'b00000, 5'b00101, 1'b0},
        {5'b00000, 1'b1, 5'b00001, 5'b00101, 1'b0},
        {5'b10100, 1'b1, 5'b10100, 5'b10101, 1'b1},
        {5'b01000, 1'b0, 5'b01000, 5'b11101, 1'b0}
    };
    localparam logic [4:0] EN_OVF = 5'b00100;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic [4:0] c, input logic [4:0] e,
                                         input logic [4:0] f, input logic [1:0] rm,
                                         input logic dn);
        return (32'(dn) << 18) | (32'(c) << 12) | (32'(e) << 7) | (32'(f) << 2) | 32'(rm);
    endfunction

    task automatic cycle(input logic w, input logic [31:0] d, input logic o,
                         input logic [4:0] x, input logic a);
        @(negedge clk);
        wr_en = w; wr_data = d; op_done = o; op_exc = x; op_approx = a;
        @(negedge clk);
        wr_en = 1'b0; op_done = 1'b0; op_exc = '0; op_approx = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset word", csr_q, 32'h0);
        check("R1 reset trap", {31'b0, trap_req}, 32'h0);
        check("R1 reset code", {20'b0, trap_code}, 32'h0);

        cycle(1'b1, 32'hFFFF_FFFF, 1'b0, '0, 1'b0);
        check("R2 masked write", csr_q, 32'h0005_FFFF);
        check("R7 rm=3 nearest", {31'b0, round_trunc}, 32'h0);
        check("R8 flush set", {31'b0, flush_denorm}, 32'h1);

        cycle(1'b1, 32'hFFF0_0201, 1'b0, '0, 1'b0);
        check("R2 masked write 2", csr_q, word('0, EN_OVF, '0, 2'd1, 1'b0));
        check("R7 rm=1 truncate", {31'b0, round_trunc}, 32'h1);
        check("R8 flush clear", {31'b0, flush_denorm}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [16:0] v;
            v = VEC[i];
            cycle(1'b0, '0, 1'b1, v[16:12], v[11]);
            check($sformatf("R3 R4 R5 vec%0d word", i), csr_q,
                  word(v[10:6], EN_OVF, v[5:1], 2'd1, 1'b0));
            check($sformatf("R6 vec%0d trap", i), {31'b0, trap_req}, {31'b0, v[0]});
            check($sformatf("R6 vec%0d code", i), {20'b0, trap_code},
                  v[0] ? 32'h120 : 32'h0);
        end

        // R6: trap lasts one cycle
        @(negedge clk);
        check("R6 trap one cycle", {31'b0, trap_req}, 32'h0);

        // R6: back-to-back enabled completions keep trap high each cycle
        @(negedge clk);
        op_done = 1'b1; op_exc = 5'b00100;
        @(negedge clk);
        check("R6 b2b first", {31'b0, trap_req}, 32'h1);
        op_exc = 5'b00110;
        @(negedge clk);
        op_done = 1'b0; op_exc = '0;
        check("R6 b2b second", {31'b0, trap_req}, 32'h1);
        check("R4 b2b flags", csr_q, word(5'b00110, EN_OVF, 5'b11111, 2'd1, 1'b0));

        // R9: write and enabled completion together; write clears flags
        cycle(1'b1, 32'h0000_0201, 1'b1, 5'b00100, 1'b0);
        check("R9 collision word", csr_q, word('0, EN_OVF, '0, 2'd1, 1'b0));
        check("R9 collision no trap", {31'b0, trap_req}, 32'h0);

        // R9: collision sets new enables, completion dropped
        cycle(1'b1, word('0, 5'b10000, '0, 2'd2, 1'b1), 1'b1, 5'b10000, 1'b0);
        check("R9 collision 2 word", csr_q, word('0, 5'b10000, '0, 2'd2, 1'b1));
        check("R9 collision 2 no trap", {31'b0, trap_req}, 32'h0);
        check("R7 rm=2 nearest", {31'b0, round_trunc}, 32'h0);

        // R5: approx with only divide-by-zero keeps it, no inexact; R3 empty completion clears cause
        cycle(1'b0, '0, 1'b1, 5'b01000, 1'b1);
        check("R5 approx with other", csr_q, word(5'b01000, 5'b10000, 5'b01000, 2'd2, 1'b1));
        cycle(1'b0, '0, 1'b1, 5'b00000, 1'b0);
        check("R3 cause cleared", csr_q, word('0, 5'b10000, 5'b01000, 2'd2, 1'b1));

        // R1: reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 re-reset", csr_q, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule